// File: doc/BRIEF.md
# Seconds Counter with Alarm Compare

This peripheral keeps wall-clock time as a free-running count of seconds. A one-cycle pulse on `secTick`, produced elsewhere at one hertz, advances a 32-bit counter. A 32-bit alarm value is compared with the counter each time it advances. Two sticky flags record what has happened: one flag for an alarm match and one for a tick. Each flag has its own enable bit, and each drives a level interrupt request toward an interrupt controller.

Software uses a plain synchronous register bus with a byte offset, a write strobe, write data and combinational read data. It can load the counter and the alarm value at any time. It acknowledges a flag by writing a one to that flag's position. A trim register stores a calibration word for software but does not change the counting. No oscillator trimming and no clock-domain crossing are done here.

Top module: `rtc_top`

## Requirements
- R1: After a synchronous reset, the alarm, count, trim and status registers all read zero, and both interrupt outputs are low.
- R2: A `secTick` pulse with no count write in the same cycle adds one to the count register in the next cycle. 0xFFFFFFFF wraps to 0.
- R3: On a tick, if the alarm enable (status bit 2) is set and the alarm register equals the new count value, the alarm flag (status bit 0) is set. It stays set on later ticks until software clears it.
- R4: On every tick while the tick enable (status bit 3) is set, the tick flag (status bit 1) is set. It stays set until software clears it.
- R5: A write at offset 0x10 clears status bit 0 or bit 1 where the written bit is 1 and leaves it alone where the written bit is 0. The same write loads bits 2 and 3 with the written values.
- R6: If a clearing write and a tick that sets the same flag fall in the same cycle, the flag stays set.
- R7: A count write (offset 0x04) in the same cycle as a tick loads the written value with no increment. The alarm compare for that tick uses the written value.
- R8: A write at offset 0x08 keeps only the low 26 bits, and bits 31:26 read as zero. The trim value has no effect on counting.
- R9: Reads at offsets other than 0x00, 0x04, 0x08 and 0x10 return zero, and writes there change no register. Status bits 31:4 always read zero.
- R10: `irqAlarm` equals status bit 0 and `irqTick` equals status bit 1, as levels.
- R11: With an enable bit clear, its flag is never set by a tick, even on an alarm match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| secTick | input | 1 | One-cycle pulse once per second |
| busAddr | input | 8 | Register byte offset |
| busWrEn | input | 1 | Write strobe for the current cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for `busAddr` |
| irqAlarm | output | 1 | Alarm interrupt request (level) |
| irqTick | output | 1 | Per-second interrupt request (level) |

## Verification
A software write and a `secTick` pulse can land in the same clock cycle. Two cases matter: a count load racing the increment, and a flag acknowledge racing a tick that would set the same flag. The bench creates both collisions by raising the write strobe and the tick in the same cycle. It then judges the outcome by reading back the count and the status word, and by watching the two interrupt outputs. The alarm compare is also swept over several tick distances, with the tick enable both on and off, so that an off-by-one in the compare timing is caught.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [7:0] OFF_ALARM  = 8'h00;
  localparam logic [7:0] OFF_COUNT  = 8'h04;
  localparam logic [7:0] OFF_TRIM   = 8'h08;
  localparam logic [7:0] OFF_STATUS = 8'h10;

  localparam int ST_ALARM_FLAG = 0;
  localparam int ST_TICK_FLAG  = 1;
  localparam int ST_ALARM_EN   = 2;
  localparam int ST_TICK_EN    = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ALARM,
    SEL_COUNT,
    SEL_TRIM,
    SEL_STATUS
  } rdSel_e;

  typedef struct packed {
    logic   wrAlarm;
    logic   wrCount;
    logic   wrTrim;
    logic   wrStatus;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output strobe_t           strobes
);
  always_comb begin
    strobes = '0;
    strobes.rdSel = SEL_NONE;
    if (busAddr == ADDR_W'(OFF_ALARM)) begin
      strobes.rdSel   = SEL_ALARM;
      strobes.wrAlarm = busWrEn;
    end else if (busAddr == ADDR_W'(OFF_COUNT)) begin
      strobes.rdSel   = SEL_COUNT;
      strobes.wrCount = busWrEn;
    end else if (busAddr == ADDR_W'(OFF_TRIM)) begin
      strobes.rdSel  = SEL_TRIM;
      strobes.wrTrim = busWrEn;
    end else if (busAddr == ADDR_W'(OFF_STATUS)) begin
      strobes.rdSel    = SEL_STATUS;
      strobes.wrStatus = busWrEn;
    end
  end

  // R9
  always_comb begin
    strobe_onehot_chk: assert ($onehot0({strobes.wrAlarm, strobes.wrCount,
                                         strobes.wrTrim, strobes.wrStatus}));
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TRIM_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              secTick,
  input  logic [DATA_W-1:0] wrData,
  input  strobe_t           strobes,
  output logic [DATA_W-1:0] rdData,
  output logic              irqAlarm,
  output logic              irqTick
);
  localparam int PAD_W = DATA_W - TRIM_W;

  logic [DATA_W-1:0] alarmReg, countReg, countNext;
  logic [TRIM_W-1:0] trimReg;
  logic alarmFlag, tickFlag, alarmEn, tickEn;
  logic alarmHit, tickHit, alarmClr, tickClr;

  always_comb begin
    if (strobes.wrCount)  countNext = wrData;
    else if (secTick)     countNext = countReg + 1'b1;
    else                  countNext = countReg;
  end

  assign alarmHit = secTick && alarmEn && (alarmReg == countNext);
  assign tickHit  = secTick && tickEn;
  assign alarmClr = strobes.wrStatus && wrData[ST_ALARM_FLAG];
  assign tickClr  = strobes.wrStatus && wrData[ST_TICK_FLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      alarmReg  <= '0;
      countReg  <= '0;
      trimReg   <= '0;
      alarmFlag <= 1'b0;
      tickFlag  <= 1'b0;
      alarmEn   <= 1'b0;
      tickEn    <= 1'b0;
    end else begin
      countReg <= countNext;
      if (strobes.wrAlarm) alarmReg <= wrData;
      if (strobes.wrTrim)  trimReg  <= wrData[TRIM_W-1:0];
      if (strobes.wrStatus) begin
        alarmEn <= wrData[ST_ALARM_EN];
        tickEn  <= wrData[ST_TICK_EN];
      end
      if (alarmHit)      alarmFlag <= 1'b1;
      else if (alarmClr) alarmFlag <= 1'b0;
      if (tickHit)       tickFlag  <= 1'b1;
      else if (tickClr)  tickFlag  <= 1'b0;
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      SEL_ALARM:  rdData = alarmReg;
      SEL_COUNT:  rdData = countReg;
      SEL_TRIM:   rdData = {{PAD_W{1'b0}}, trimReg};
      SEL_STATUS: rdData = {{(DATA_W-4){1'b0}}, tickEn, alarmEn, tickFlag, alarmFlag};
      default:    rdData = '0;
    endcase
  end

  assign irqAlarm = alarmFlag;
  assign irqTick  = tickFlag;

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (secTick && !strobes.wrCount) |=> countReg == $past(countReg) + 1'b1);

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!secTick && !strobes.wrCount) |=> $stable(countReg));

  // R3
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (alarmFlag && !strobes.wrStatus) |=> alarmFlag);

  // R4
  tick_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (secTick && tickEn) |=> tickFlag);

  // R11
  alarm_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!alarmFlag && !alarmEn) |=> !alarmFlag);

  // R7
  count_load_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.wrCount |=> countReg == $past(wrData));
endmodule

// File: rtl/rtc_top.sv
module rtc_top
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int TRIM_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              secTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqAlarm,
  output logic              irqTick
);
  strobe_t strobes;

  rtc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobes (strobes)
  );

  rtc_datapath #(.DATA_W(DATA_W), .TRIM_W(TRIM_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .secTick  (secTick),
    .wrData   (busWrData),
    .strobes  (strobes),
    .rdData   (busRdData),
    .irqAlarm (irqAlarm),
    .irqTick  (irqTick)
  );

  // R9
  status_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    (busAddr == ADDR_W'(OFF_STATUS)) |-> busRdData[DATA_W-1:4] == '0);

  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    (busAddr == ADDR_W'(OFF_STATUS)) |-> (busRdData[1:0] == {irqTick, irqAlarm}));
endmodule

// File: tb/rtc_top_tb.sv
module rtc_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        secTick = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqAlarm, irqTick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_top u_dut (
    .clk(clk), .rst(rst), .secTick(secTick), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqAlarm(irqAlarm), .irqTick(irqTick)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write, optionally with a tick in the same cycle
  task automatic wr(logic [7:0] a, logic [31:0] d, bit withTick = 1'b0);
    busAddr = a; busWrData = d; busWrEn = 1'b1; secTick = withTick;
    @(negedge clk);
    busWrEn = 1'b0; secTick = 1'b0;
  endtask

  task automatic tk(int n = 1);
    for (int i = 0; i < n; i++) begin
      secTick = 1'b1;
      @(negedge clk);
      secTick = 1'b0;
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    busAddr = a;
    #1 v = busRdData;
  endtask

  initial begin
    logic [31:0] v;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h00, v); chk("R1 alarm", v, 0);
    rd(8'h04, v); chk("R1 count", v, 0);
    rd(8'h08, v); chk("R1 trim", v, 0);
    rd(8'h10, v); chk("R1 status", v, 0);
    chk("R1 irq", {irqTick, irqAlarm}, 0);

    // R2 increment and wrap
    wr(8'h04, 32'd5); tk(3);
    rd(8'h04, v); chk("R2 count+3", v, 32'd8);
    wr(8'h04, 32'hFFFF_FFFF); tk();
    rd(8'h04, v); chk("R2 wrap", v, 32'd0);

    // R11 enables clear: no flags even on match
    wr(8'h00, 32'd1); tk();
    rd(8'h10, v); chk("R11 status", v, 0);
    chk("R11 irq", {irqTick, irqAlarm}, 0);

    // R3/R4/R10 sweep over tick distance and tick enable
    for (int k = 1; k <= 6; k++) begin
      for (int hz = 0; hz < 2; hz++) begin
        logic [31:0] base;
        base = 32'd100 * k;
        wr(8'h10, (32'(hz) << 3) | 32'h7);
        wr(8'h04, base);
        wr(8'h00, base + k);
        if (k > 1) begin
          tk(k - 1);
          chk($sformatf("R3 early k=%0d hz=%0d", k, hz), irqAlarm, 0);
          chk($sformatf("R4 tick hz=%0d", hz), irqTick, hz);
        end
        tk();
        chk($sformatf("R3 hit k=%0d hz=%0d", k, hz), irqAlarm, 1);
        tk(2);
        chk($sformatf("R3 sticky k=%0d", k), irqAlarm, 1);
        rd(8'h10, v);
        chk($sformatf("R10 status k=%0d hz=%0d", k, hz), v,
            (32'(hz) << 3) | 32'h4 | (32'(hz) << 1) | 32'h1);
        chk("R10 irq", {irqTick, irqAlarm}, {v[1], v[0]});
      end
    end

    // R5 clear alarm flag only, keep both enables
    wr(8'h10, 32'hC | 32'h1);
    rd(8'h10, v); chk("R5 clear alarm", v, 32'hE);
    wr(8'h10, 32'h2);
    rd(8'h10, v); chk("R5 clear tick and enables", v, 32'h0);

    // R6 clear collides with setting tick
    wr(8'h10, 32'hC); wr(8'h04, 32'd9); wr(8'h00, 32'd10);
    tk(); // count 10: alarm flag and tick flag set
    rd(8'h10, v); chk("R6 pre", v, 32'hF);
    wr(8'h00, 32'd11);
    wr(8'h10, 32'hF, 1'b1); // clear both, tick matches 11
    rd(8'h10, v); chk("R6 set wins", v, 32'hF);

    // R7 count write collides with tick
    wr(8'h10, 32'h7);
    wr(8'h00, 32'd50);
    wr(8'h04, 32'd50, 1'b1);
    rd(8'h04, v); chk("R7 count", v, 32'd50);
    chk("R7 alarm on written", irqAlarm, 1);

    // R8 trim
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); chk("R8 trim", v, 32'h03FF_FFFF);
    tk();
    rd(8'h04, v); chk("R8 count unaffected", v, 32'd51);

    // R9 unmapped offsets
    wr(8'h0C, 32'hDEAD_BEEF); wr(8'h14, 32'hFFFF_FFFF); wr(8'hFC, 32'h1234);
    rd(8'h0C, v); chk("R9 read 0C", v, 0);
    rd(8'h14, v); chk("R9 read 14", v, 0);
    rd(8'h00, v); chk("R9 alarm kept", v, 32'd50);
    rd(8'h04, v); chk("R9 count kept", v, 32'd51);
    rd(8'h08, v); chk("R9 trim kept", v, 32'h03FF_FFFF);
    wr(8'h10, 32'hFFFF_FFF0);
    rd(8'h10, v); chk("R9 status reserved", v, 32'h1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule